// File: doc/BRIEF.md
# Dual Interval Timer with Status Flags and Interrupt

This block holds two independent down-counting interval timers. Software programs them through a simple register write port (address, data, strobe). The first timer takes a 10-bit setting split over two registers. The second takes an 8-bit setting and counts on a 16× coarser scale. Each timer advances only on cycles when its tick enable input is high, so the surrounding chip chooses the real time base.

One control register does several jobs. It starts and stops each timer, lets each timer raise a sticky status flag on overflow, clears those flags, and selects an operating mode. The two flags appear on a status byte that is always readable, and an interrupt line is raised while any unmasked flag is set. In the composite-sine mode, every overflow of the first timer also produces a one-cycle key-on request aimed at the third voice channel. The block only issues that request; acting on it is left to the channel logic.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset the status byte is 0x00, `irq` and `keyon_req` are low, both timers are stopped, all flag enables are off and the mode is normal.
- R2: Timer A runs for 1024 − TA ticks of `tick_a`, where TA[9:2] is written at address 0x24 and TA[1:0] is taken from data bits 1:0 at address 0x25.
- R3: Timer B runs for (256 − TB)·16 ticks of `tick_b`, where TB is written at address 0x26.
- R4: On overflow a running timer reloads itself with the same period and keeps counting.
- R5: Writing address 0x27 with bit 0 (timer A) or bit 1 (timer B) set starts that timer with a full period only if it is stopped; if it is already running, the write leaves its count untouched.
- R6: Writing address 0x27 with a timer's start bit at 0 stops that timer, and a stopped timer never overflows.
- R7: An overflow sets the timer's flag only while its flag-enable bit in register 0x27 is set (bit 2 for A, bit 3 for B).
- R8: Writing address 0x27 with bit 4 (A) or bit 5 (B) set clears that flag at the same clock edge, and this wins over an overflow at that edge.
- R9: The status byte shows flag A in bit 0, flag B in bit 1 and zeros above. `irq` is high exactly when the status AND the interrupt mask (default 0x03) is nonzero.
- R10: While bits 7:6 of register 0x27 equal 2'b10 (composite-sine mode), each timer A overflow drives `keyon_req` high for exactly one cycle, at the edge that follows the overflowing tick. Other mode values never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| tick_a | input | 1 | Count enable for timer A |
| tick_b | input | 1 | Count enable for timer B |
| status | output | 8 | Status byte: bit 0 flag A, bit 1 flag B |
| irq | output | 1 | Interrupt, high while a masked flag is set |
| keyon_req | output | 1 | One-cycle key-on request in composite-sine mode |

## Verification
The bench targets the exact period lengths, including the low two bits of timer A and the ×16 scale of timer B. A design that mis-assembled the setting or dropped the prescale would raise a flag one tick too early or too late. It also writes the start bit again while a timer runs; a design that restarted the count would miss the expected overflow. A flag clear is made to land on the same edge as an overflow, where a design with the wrong priority leaves the flag set. Finally, it runs with flag enables off and with the non-composite modes, where a loosely gated design would set flags or emit spurious key-on pulses.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int TA_W = 10;
  localparam int TB_W = 8;
  localparam int TB_PRE_SH = 4;

  localparam logic [7:0] ADDR_TA_HI = 8'h24;
  localparam logic [7:0] ADDR_TA_LO = 8'h25;
  localparam logic [7:0] ADDR_TB    = 8'h26;
  localparam logic [7:0] ADDR_CTRL  = 8'h27;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_SPLIT   = 2'b01,
    MODE_CSM     = 2'b10,
    MODE_SPLIT_X = 2'b11
  } tmode_e;

  // Control byte layout: [7:6] mode, [5:4] flag clear, [3:2] flag enable, [1:0] start
  typedef struct packed {
    tmode_e     mode;
    logic [1:0] clr;
    logic [1:0] flag_en;
    logic [1:0] start;
  } ctrl_t;
endpackage

// File: rtl/dtim_counter.sv
module dtim_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             tick,
  output logic             running,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (stop_req) begin
      run_d = 1'b0;
    end else if (start_req && !run_q) begin
      run_d = 1'b1;
      cnt_d = period;
    end else if (run_q && tick) begin
      cnt_d = (cnt_q == ONE) ? period : cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign running = run_q;
  assign ovf     = run_q && tick && (cnt_q == ONE) && !stop_req;

  // R6
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !running);

  // R4
  nonzero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q != '0));

  // R5
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !stop_req) |=> $stable(cnt_q));
endmodule

// File: rtl/dtim_flags.sv
module dtim_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ovf,
  input  logic [N-1:0] flag_en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr[g])
        flag_d[g] = 1'b0;
      else if (ovf[g] && flag_en[g])
        flag_d[g] = 1'b1;
    end

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] |=> !flags[g]);

    // R7
    set_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[g] && ovf[g] && flag_en[g]) |=> flags[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dtim_pkg::*;
#(
  parameter logic [1:0] IRQ_MASK = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       tick_a,
  input  logic       tick_b,
  output logic [7:0] status,
  output logic       irq,
  output logic       keyon_req
);
  localparam int CNT_A_W = TA_W + 1;
  localparam int CNT_B_W = TB_W + 1 + TB_PRE_SH;

  logic [TA_W-1:0] ta_q, ta_d;
  logic [TB_W-1:0] tb_q, tb_d;
  logic [1:0]      en_q, en_d;
  tmode_e          mode_q, mode_d;
  logic            keyon_q, keyon_d;

  ctrl_t           wr_ctrl;
  logic            ctrl_wr;
  logic [1:0]      start_req, stop_req, clr_req, ovf, flags;
  logic [CNT_A_W-1:0] period_a;
  logic [CNT_B_W-1:0] period_b;
  logic               run_a, run_b;

  assign wr_ctrl = ctrl_t'(wr_data);
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  assign start_req = ctrl_wr ? wr_ctrl.start  : 2'b00;
  assign stop_req  = ctrl_wr ? ~wr_ctrl.start : 2'b00;
  assign clr_req   = ctrl_wr ? wr_ctrl.clr    : 2'b00;

  assign period_a = CNT_A_W'(1 << TA_W) - CNT_A_W'(ta_q);
  assign period_b = CNT_B_W'((CNT_B_W'(1 << TB_W) - CNT_B_W'(tb_q)) << TB_PRE_SH);

  always_comb begin
    ta_d   = ta_q;
    tb_d   = tb_q;
    en_d   = en_q;
    mode_d = mode_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_TA_HI: ta_d[TA_W-1:2] = wr_data[TA_W-3:0];
        ADDR_TA_LO: ta_d[1:0]      = wr_data[1:0];
        ADDR_TB:    tb_d           = wr_data[TB_W-1:0];
        ADDR_CTRL: begin
          en_d   = wr_ctrl.flag_en;
          mode_d = wr_ctrl.mode;
        end
        default: ;
      endcase
    end
    keyon_d = ovf[0] && (mode_q == MODE_CSM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q    <= '0;
      tb_q    <= '0;
      en_q    <= 2'b00;
      mode_q  <= MODE_NORMAL;
      keyon_q <= 1'b0;
    end else begin
      ta_q    <= ta_d;
      tb_q    <= tb_d;
      en_q    <= en_d;
      mode_q  <= mode_d;
      keyon_q <= keyon_d;
    end
  end

  dtim_counter #(.CNT_W(CNT_A_W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .period(period_a),
    .start_req(start_req[0]), .stop_req(stop_req[0]), .tick(tick_a),
    .running(run_a), .ovf(ovf[0])
  );

  dtim_counter #(.CNT_W(CNT_B_W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .period(period_b),
    .start_req(start_req[1]), .stop_req(stop_req[1]), .tick(tick_b),
    .running(run_b), .ovf(ovf[1])
  );

  dtim_flags #(.N(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .flag_en(en_q),
    .clr(clr_req), .flags(flags)
  );

  assign status    = {6'b0, flags};
  assign irq       = |(flags & IRQ_MASK);
  assign keyon_req = keyon_q;

  // R10
  csm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyon_q |-> $past(mode_q == MODE_CSM));

  // R6
  idle_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a |-> !ovf[0]) and (!run_b |-> !ovf[1]));
endmodule

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       tick_a;
  logic       tick_b;
  logic [7:0] status;
  logic       irq;
  logic       keyon_req;

  int checks = 0;
  int errors = 0;

  dual_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_a(tick_a), .tick_b(tick_b),
    .status(status), .irq(irq), .keyon_req(keyon_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tick_a = 1'b0; tick_b = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input bit which_b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which_b) tick_b = 1'b1; else tick_a = 1'b1;
      @(negedge clk);
      tick_a = 1'b0; tick_b = 1'b0;
    end
  endtask

  // A period of 4 ticks: TA = 1020
  task automatic set_ta4();
    wr(8'h24, 8'hFF);
    wr(8'h25, 8'h00);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 status", status, 0);
    check("R1 irq", irq, 0);
    check("R1 keyon", keyon_req, 0);
    set_ta4();
    wr(8'h27, 8'h05);
    ticks(0, 4);
    check("R1 flag before reset", status, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 status after reset", status, 0);
    set_ta4();
    wr(8'h27, 8'h04);
    ticks(0, 10);
    check("R1 timer stopped after reset", status, 0);
  endtask

  task automatic t_period_a();
    do_reset();
    set_ta4();
    wr(8'h27, 8'h05);
    ticks(0, 3);
    check("R2 no flag at 3", status, 0);
    ticks(0, 1);
    check("R2 flag at 4", status, 1);
    check("R9 irq on A", irq, 1);
    wr(8'h27, 8'h15);
    check("R8 cleared", status, 0);
    check("R9 irq low", irq, 0);
    ticks(0, 3);
    check("R4 no flag at 3 after reload", status, 0);
    ticks(0, 1);
    check("R4 flag after reload", status, 1);
    do_reset();
    wr(8'h24, 8'hFF);
    wr(8'h25, 8'h02);
    wr(8'h27, 8'h05);
    ticks(0, 1);
    check("R2 low bits no flag at 1", status, 0);
    ticks(0, 1);
    check("R2 low bits flag at 2", status, 1);
  endtask

  task automatic t_period_b();
    do_reset();
    wr(8'h26, 8'hFF);
    wr(8'h27, 8'h0A);
    ticks(1, 15);
    check("R3 no flag at 15", status, 0);
    ticks(1, 1);
    check("R3 flag at 16", status, 2);
    check("R9 irq on B", irq, 1);
    do_reset();
    wr(8'h26, 8'hFE);
    wr(8'h27, 8'h0A);
    ticks(1, 31);
    check("R3 no flag at 31", status, 0);
    ticks(1, 1);
    check("R3 flag at 32", status, 2);
  endtask

  task automatic t_start_stop();
    do_reset();
    set_ta4();
    wr(8'h27, 8'h05);
    ticks(0, 2);
    wr(8'h27, 8'h05);
    ticks(0, 2);
    check("R5 restart ignored while running", status, 1);
    do_reset();
    set_ta4();
    wr(8'h27, 8'h05);
    ticks(0, 2);
    wr(8'h27, 8'h04);
    ticks(0, 10);
    check("R6 stopped timer silent", status, 0);
    wr(8'h27, 8'h05);
    ticks(0, 3);
    check("R5 fresh period no flag at 3", status, 0);
    ticks(0, 1);
    check("R5 fresh period flag at 4", status, 1);
  endtask

  task automatic t_enable_clear();
    do_reset();
    set_ta4();
    wr(8'h27, 8'h01);
    ticks(0, 4);
    check("R7 no flag when disabled", status, 0);
    wr(8'h27, 8'h05);
    ticks(0, 4);
    check("R7 flag when enabled", status, 1);
    wr(8'h27, 8'h15);
    ticks(0, 3);
    @(negedge clk);
    tick_a = 1'b1; wr_en = 1'b1; wr_addr = 8'h27; wr_data = 8'h15;
    @(negedge clk);
    tick_a = 1'b0; wr_en = 1'b0;
    check("R8 clear beats overflow", status, 0);
    ticks(0, 4);
    check("R8 R4 flag after next period", status, 1);
  endtask

  task automatic t_csm();
    do_reset();
    set_ta4();
    wr(8'h27, 8'h81);
    ticks(0, 3);
    check("R10 no pulse before ovf", keyon_req, 0);
    @(negedge clk);
    tick_a = 1'b1;
    @(negedge clk);
    tick_a = 1'b0;
    check("R10 pulse on ovf", keyon_req, 1);
    check("R7 no flag in csm without enable", status, 0);
    @(negedge clk);
    check("R10 pulse one cycle", keyon_req, 0);
    do_reset();
    set_ta4();
    wr(8'h27, 8'h45);
    ticks(0, 4);
    check("R10 no pulse mode 01", keyon_req, 0);
    check("R10 flag still set mode 01", status, 1);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_period_a();
    t_period_b();
    t_start_stop();
    t_enable_clear();
    t_csm();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule